// File: doc/BRIEF.md
# Decoupled Memory Slot Controller

This block serves the memory half of a two-issue instruction word. Next to each ordinary operation the front end presents an 8-bit memory slot. The slot holds an operation code and a register index. The block decodes the slot and sends loads, stores and prefetches to a request/response memory port. It records each request in an in-order tracking queue. It then lets the front end move on without waiting for the data.

Responses come back in request order after any latency. Each response retires the oldest tracked entry. A load response goes out on a write-back port, tagged with the destination register. The only way to wait for memory is a sync slot. The block holds a sync with its stall output until nothing is in flight. If nothing is in flight, the sync passes at once.

Top module: `memslot_ctrl`

## Requirements
- R1: The slot code is decoded with bits [7:6] as the operation and bits [5:0] as the register index. The operation values are 00 no-op, 01 load, 10 store and 11 sync.
- R2: A load raises `mem_req_valid` with `mem_req_write` low and `mem_req_addr` equal to `opnd_addr`. The slot is accepted (`slot_ready` high) without waiting for the data.
- R3: A store raises `mem_req_valid` with `mem_req_write` high, `mem_req_addr` equal to `opnd_addr` and `mem_req_wdata` equal to `opnd_wdata`.
- R4: A no-op naming register 0 makes no memory request and is always accepted. A no-op naming any other register is a prefetch: a read request to `opnd_addr`.
- R5: While a sync is presented and any operation is in flight, `stall` is high and `slot_ready` is low. The sync is released in the same cycle the last response arrives. With nothing in flight it is released at once.
- R6: At most 8 operations are in flight. When 8 are in flight, `slot_ready` and `mem_req_valid` are low for a memory operation. They rise in the cycle after a response retires an entry. `slot_ready` is also low for a memory operation while `mem_req_ready` is low.
- R7: Responses retire entries in request order. A load response drives `wb_valid` with `wb_reg` set to the load's register index and `wb_data` set to `mem_rsp_rdata`, in the same cycle, one per cycle.
- R8: Responses to stores and prefetches produce no write-back.
- R9: A load naming register 0 is sent to memory, but its response produces no write-back.
- R10: After reset nothing is in flight, and `mem_req_valid`, `wb_valid` and `stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | Memory slot presented |
| slot_code | input | 8 | Operation (bits 7:6) and register index (bits 5:0) |
| slot_ready | output | 1 | Slot accepted this cycle |
| opnd_addr | input | ADDR_W | Address read from the named register |
| opnd_wdata | input | DATA_W | Store data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Request write data |
| mem_rsp_valid | input | 1 | Response for the oldest request |
| mem_rsp_rdata | input | DATA_W | Response data |
| wb_valid | output | 1 | Register write-back this cycle |
| wb_reg | output | 6 | Write-back register index |
| wb_data | output | DATA_W | Write-back data |
| stall | output | 1 | Front end held by a sync |

## Verification
The assertions assume two things about the memory side. First, it never sends a response while nothing is in flight. Second, responses come back strictly in the order the requests were accepted. The bench's memory side respects both. It sends one response per tracked request, and it only sends a response after the matching request has been accepted. All inputs change on the falling edge, so the design sees a stable slot and response at each rising edge.

// File: rtl/memslot_pkg.sv
package memslot_pkg;
    localparam int SLOT_W = 8;
    localparam int OP_W   = 2;
    localparam int REG_W  = SLOT_W - OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_SYNC  = 2'b11
    } slot_op_e;

    typedef struct packed {
        logic             issue;
        logic             write;
        logic             is_sync;
        logic             wb_en;
        logic [REG_W-1:0] reg_idx;
    } slot_dec_t;

    typedef struct packed {
        logic             wb_en;
        logic [REG_W-1:0] tag;
    } track_t;
endpackage

// File: rtl/slot_decoder.sv
module slot_decoder
    import memslot_pkg::*;
(
    input  logic [SLOT_W-1:0] code,
    output slot_dec_t         dec
);
    slot_op_e         op;
    logic [REG_W-1:0] ridx;

    always_comb begin
        op   = slot_op_e'(code[SLOT_W-1 -: OP_W]);
        ridx = code[REG_W-1:0];
        dec  = '0;
        dec.reg_idx = ridx;
        case (op)
            OP_LOAD: begin
                dec.issue = 1'b1;
                dec.wb_en = (ridx != '0);
            end
            OP_STORE: begin
                dec.issue = 1'b1;
                dec.write = 1'b1;
            end
            OP_SYNC: dec.is_sync = 1'b1;
            default: dec.issue = (ridx != '0);
        endcase
    end
endmodule

// File: rtl/op_tracker.sv
module op_tracker
    import memslot_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  track_t push_ent,
    input  logic   pop,
    output track_t head_ent,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic   full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        track_t [DEPTH-1:0] ent;
        logic   [PW-1:0]    wr;
        logic   [PW-1:0]    rd;
        logic   [CW-1:0]    cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.ent[st_q.wr] = push_ent;
            st_d.wr = (st_q.wr == PW'(DEPTH-1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == PW'(DEPTH-1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_ent = st_q.ent[st_q.rd];
    assign count    = st_q.cnt;
    assign full     = (st_q.cnt == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt < CW'(DEPTH))); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0)); // R7
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R6
endmodule

// File: rtl/memslot_ctrl.sv
module memslot_ctrl
    import memslot_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_valid,
    input  logic [7:0]        slot_code,
    output logic              slot_ready,
    input  logic [ADDR_W-1:0] opnd_addr,
    input  logic [DATA_W-1:0] opnd_wdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic              wb_valid,
    output logic [5:0]        wb_reg,
    output logic [DATA_W-1:0] wb_data,
    output logic              stall
);
    localparam int CW = $clog2(DEPTH+1);

    slot_dec_t       dec;
    track_t          head_ent;
    track_t          new_ent;
    logic [CW-1:0]   pending;
    logic            full;
    logic            push;
    logic            drain_done;

    slot_decoder u_dec (
        .code (slot_code),
        .dec  (dec)
    );

    op_tracker #(.DEPTH(DEPTH)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent (new_ent),
        .pop      (mem_rsp_valid),
        .head_ent (head_ent),
        .count    (pending),
        .full     (full)
    );

    always_comb begin
        drain_done    = (pending == '0) || ((pending == CW'(1)) && mem_rsp_valid);
        mem_req_valid = slot_valid && dec.issue && !full;
        mem_req_write = dec.write;
        mem_req_addr  = opnd_addr;
        mem_req_wdata = opnd_wdata;
        push          = mem_req_valid && mem_req_ready;
        new_ent.wb_en = dec.wb_en;
        new_ent.tag   = dec.reg_idx;
        if (dec.issue)        slot_ready = !full && mem_req_ready;
        else if (dec.is_sync) slot_ready = drain_done;
        else                  slot_ready = 1'b1;
        stall    = slot_valid && dec.is_sync && !drain_done;
        wb_valid = mem_rsp_valid && head_ent.wb_en;
        wb_reg   = head_ent.tag;
        wb_data  = mem_rsp_rdata;
    end

    AST_SYNC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (pending != '0)); // R5
    AST_WB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_reg != '0)); // R9
    AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (pending < CW'(DEPTH))); // R6
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_code == 8'h00) |-> (!mem_req_valid && slot_ready)); // R4
    AST_WB_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> mem_rsp_valid); // R7
endmodule

// File: tb/memslot_ctrl_test.sv
module memslot_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        slot_valid;
    logic [7:0]  slot_code;
    logic        slot_ready;
    logic [15:0] opnd_addr;
    logic [31:0] opnd_wdata;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [15:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        wb_valid;
    logic [5:0]  wb_reg;
    logic [31:0] wb_data;
    logic        stall;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    memslot_ctrl uut (.*);

    always #4 clk = ~clk;

    typedef struct packed {
        logic [7:0]  code;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic        req;
        logic        wr;
        logic        wb;
        logic [5:0]  tag;
        logic [31:0] rdata;
    } vec_t;

    // load r5, nop r0, store r3, prefetch r7, load r0, load r9
    localparam vec_t VEC [0:5] = '{
        '{8'h45, 16'h0100, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 6'd5, 32'hA5A5_0001},
        '{8'h00, 16'h0F00, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 6'd0, 32'h0000_0000},
        '{8'h83, 16'h0200, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 6'd0, 32'h0000_0002},
        '{8'h07, 16'h0300, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 6'd0, 32'h0000_0003},
        '{8'h40, 16'h0400, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 6'd0, 32'h0000_0004},
        '{8'h49, 16'h0500, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 6'd9, 32'h1234_5678}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; slot_valid = 1'b0; slot_code = 8'h00;
        opnd_addr = '0; opnd_wdata = '0; mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: idle state after reset
        chk(mem_req_valid, 0, "R10 req");
        chk(wb_valid, 0, "R10 wb");
        chk(stall, 0, "R10 stall");
        chk(slot_ready, 1, "R10 ready");
        // R5: sync with nothing pending releases at once
        slot_valid = 1'b1; slot_code = 8'hC0;
        #1;
        chk(stall, 0, "R5 empty sync stall");
        chk(slot_ready, 1, "R5 empty sync ready");

        // R1 R2 R3 R4: vector walk, issue phase
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            slot_valid = 1'b1; slot_code = VEC[i].code;
            opnd_addr = VEC[i].addr; opnd_wdata = VEC[i].wdata;
            #1;
            chk(mem_req_valid, VEC[i].req, "R1 R4 request");
            chk(slot_ready, 1, "R2 no wait for data");
            if (VEC[i].req) begin
                chk(mem_req_write, VEC[i].wr, "R3 write flag");
                chk(mem_req_addr, VEC[i].addr, "R2 address");
                if (VEC[i].wr) chk(mem_req_wdata, VEC[i].wdata, "R3 wdata");
            end
        end
        @(negedge clk);
        slot_code = 8'hC0;
        #1;
        chk(stall, 1, "R5 sync stalls");
        chk(slot_ready, 0, "R5 sync held");

        // R7 R8 R9: response phase in order, sync held
        for (int i = 0; i < 6; i++) begin
            if (VEC[i].req) begin
                @(negedge clk);
                mem_rsp_valid = 1'b1; mem_rsp_rdata = VEC[i].rdata;
                #1;
                chk(wb_valid, VEC[i].wb, "R7 R8 R9 wb valid");
                if (VEC[i].wb) begin
                    chk(wb_reg, 32'(VEC[i].tag), "R7 wb tag");
                    chk(wb_data, VEC[i].rdata, "R7 wb data");
                end
                chk(stall, (i == 5) ? 0 : 1, "R5 release timing");
                chk(slot_ready, (i == 5) ? 1 : 0, "R5 ready timing");
            end
        end
        @(negedge clk);
        mem_rsp_valid = 1'b0; slot_valid = 1'b0;

        // R6: fill the queue
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            slot_valid = 1'b1; slot_code = 8'h40 | 8'(k + 1); opnd_addr = 16'(k);
            #1;
            chk(slot_ready, 1, "R6 room");
        end
        @(negedge clk);
        slot_code = 8'h4A;
        #1;
        chk(slot_ready, 0, "R6 full ready");
        chk(mem_req_valid, 0, "R6 full req");
        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_rdata = 32'h0000_0100;
        #1;
        chk(wb_reg, 1, "R7 oldest first");
        chk(slot_ready, 0, "R6 same-cycle retire");
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        #1;
        chk(slot_ready, 1, "R6 ready after retire");
        chk(mem_req_valid, 1, "R6 req after retire");
        @(negedge clk);
        slot_valid = 1'b0;
        for (int k = 0; k < 8; k++) begin
            mem_rsp_valid = 1'b1; mem_rsp_rdata = 32'(k);
            #1;
            chk(wb_reg, (k < 7) ? 32'(k + 2) : 32'd10, "R7 order");
            @(negedge clk);
        end
        mem_rsp_valid = 1'b0;

        // R6: memory backpressure
        mem_req_ready = 1'b0; slot_valid = 1'b1; slot_code = 8'h44;
        #1;
        chk(slot_ready, 0, "R6 backpressure ready");
        chk(mem_req_valid, 1, "R6 backpressure req");
        @(negedge clk);
        mem_req_ready = 1'b1; slot_code = 8'hC0;
        #1;
        chk(stall, 0, "R5 nothing pending");
        @(negedge clk);
        slot_valid = 1'b0;
        done = 1'b1;
        finish_run();
    end
endmodule